// File: doc/BRIEF.md
# FM separated bit decoder

This block sits between an external phase-locked data separator and the byte engine of a single-density (FM) floppy controller. It receives the separator's two outputs, a separated clock (a square wave, one period per bit cell, nominally 4 µs) and a separated data line carrying pulses. Both are sampled on a much faster system clock. The block turns them into one decoded bit per cell, with a one-cycle valid strobe.

Inside each cell, the low half of the separated clock is treated as the clock window and the high half as the data window. A pulse in the data window is a one, and an empty data window is a zero. A pulse in the clock window records that the cell's clock bit is present. The block keeps the last eight cells of both data and clock history. When the pair matches one of the four address-mark signatures (index, ID, data, deleted data), it reports which mark was found. That mark also sets byte alignment, and from then on a byte is delivered every eighth cell, most significant bit first.

The separated data line can be declared active-low by a parameter. It is then inverted ahead of the synchroniser, so the decoder itself always works in positive logic.

Top module: `fm_sep_decoder`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `bit_vld_o`, `byte_vld_o` and `mark_vld_o` are low and `byte_o` is zero.
- R2: A cell ends at every falling edge of the separated clock. Each cell gives exactly one single-cycle `bit_vld_o` pulse, and no other pulses occur.
- R3: `bit_o` is 1 when a rising edge of positive-logic data fell in the cell's data window (separated clock high), and 0 otherwise. A pulse in the clock window (separated clock low) marks the clock bit as present and does not set `bit_o`.
- R4: With `DATA_ACTIVE_LOW` = 1, an inverted data line produces the same bits, bytes and marks that the non-inverted line produces with the parameter at 0.
- R5: Over the last eight cells, oldest cell in the MSB, the following data/clock pairs are recognised, and each gives a one-cycle `mark_vld_o` on the cell that completes it:

  | Mark | Data | Clock pattern | `mark_type_o` |
  |---|---|---|---|
  | index | 0xFC | 0xD7 | 0 |
  | ID | 0xFE | 0xC7 | 1 |
  | data | 0xFB | 0xC7 | 2 |
  | deleted data | 0xF8 | 0xC7 | 3 |
- R6: A mark data value with any other clock pattern raises no `mark_vld_o`. This includes all clock bits present, and 0xFE with clock pattern 0xD7.
- R7: After a mark, `byte_vld_o` pulses on every eighth following cell. `byte_o` then holds those eight cell bits, the first received bit in the MSB.
- R8: A mark that arrives while aligned restarts the eight-cell count from that mark. A count that completes before the new mark still delivers its byte, built from the last eight cells.
- R9: No `byte_vld_o` is raised before the first mark after reset.
- R10: A reset in the middle of a stream clears alignment. Byte output stays silent until a new mark is seen.
- R11: When a mark completes on the cell that would also complete a byte, only `mark_vld_o` is raised, and the count restarts from the mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the cell rate |
| rst_n | input | 1 | Synchronous active-low reset |
| sep_clk_i | input | 1 | Separated clock from the data separator, one period per cell |
| sep_data_i | input | 1 | Separated data pulses; polarity set by `DATA_ACTIVE_LOW` |
| bit_o | output | 1 | Decoded bit of the latest cell |
| bit_vld_o | output | 1 | One-cycle strobe per completed cell |
| byte_o | output | 8 | Assembled byte, first bit in the MSB |
| byte_vld_o | output | 1 | One-cycle strobe when `byte_o` is new |
| mark_vld_o | output | 1 | One-cycle strobe when an address mark completes |
| mark_type_o | output | 2 | 0 index, 1 ID, 2 data, 3 deleted data |

## Verification
The properties assume that every cell lasts several system cycles, so that two cell strobes can never fall on adjacent cycles. They also assume that a data pulse never rises on the same sampled cycle as a separated-clock edge, which would make its window ambiguous. The stimulus keeps to both assumptions by giving each half cell sixteen system cycles and placing each three-cycle pulse in the middle of its half. The bench drives a plain and an active-low instance in parallel. Both are swept through all 256 byte values after a mark, every mark type, a wrong-clock lookalike, a mid-byte resynchronisation and a mid-stream reset.

// File: rtl/fmd_pkg.sv
// Shared constants and types for the FM separated bit decoder.
// Assumes FM single density: eight cells per byte, four address-mark kinds.
package fmd_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MK_INDEX   = 2'd0,
        MK_ID      = 2'd1,
        MK_DATA    = 2'd2,
        MK_DELETED = 2'd3
    } mark_e;

    // Data values of the four marks and their missing-clock signatures
    localparam logic [BYTE_W-1:0] SIG_INDEX_DAT = 8'hFC;
    localparam logic [BYTE_W-1:0] SIG_INDEX_CLK = 8'hD7;
    localparam logic [BYTE_W-1:0] SIG_ID_DAT    = 8'hFE;
    localparam logic [BYTE_W-1:0] SIG_DATA_DAT  = 8'hFB;
    localparam logic [BYTE_W-1:0] SIG_DEL_DAT   = 8'hF8;
    localparam logic [BYTE_W-1:0] SIG_MARK_CLK  = 8'hC7;

    typedef struct packed {
        logic  hit;
        mark_e kind;
    } mark_hit_t;

    // Classify an eight-cell window of data and clock history
    function automatic mark_hit_t mark_lookup(input logic [BYTE_W-1:0] dat,
                                              input logic [BYTE_W-1:0] clk);
        mark_hit_t r;
        r.hit  = 1'b0;
        r.kind = MK_INDEX;
        if (dat == SIG_INDEX_DAT && clk == SIG_INDEX_CLK) begin
            r.hit  = 1'b1;
            r.kind = MK_INDEX;
        end else if (clk == SIG_MARK_CLK) begin
            if (dat == SIG_ID_DAT) begin
                r.hit  = 1'b1;
                r.kind = MK_ID;
            end else if (dat == SIG_DATA_DAT) begin
                r.hit  = 1'b1;
                r.kind = MK_DATA;
            end else if (dat == SIG_DEL_DAT) begin
                r.hit  = 1'b1;
                r.kind = MK_DELETED;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/fmd_sync.sv
// Multi-stage synchroniser for a small bundle of asynchronous inputs.
// Assumes each bit changes slowly compared with clk; bits are not
// guaranteed to stay coherent with one another, only individually stable.
module fmd_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage captures the raw asynchronous level
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_i;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each later stage resamples the one before it
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/fmd_cell.sv
// Cell framer: splits each separated-clock period into a clock window
// (level low) and a data window (level high), and records whether a data
// pulse rose in each. A cell closes on the falling edge of the window
// signal. Assumes synchronised, positive-logic inputs.
module fmd_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic win_i,
    input  logic pulse_i,
    output logic cell_stb_o,
    output logic cell_clk_o,
    output logic cell_dat_o
);

    logic win_q, pul_q;
    logic seen_clk_q, seen_dat_q;
    logic pul_rise, win_fall;

    // Edge detection on the synchronised signals
    always_comb begin
        pul_rise = pulse_i & ~pul_q;
        win_fall = ~win_i & win_q;
    end

    // Track pulses per window and hand off a cell on each window fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q      <= 1'b0;
            pul_q      <= 1'b0;
            seen_clk_q <= 1'b0;
            seen_dat_q <= 1'b0;
            cell_stb_o <= 1'b0;
            cell_clk_o <= 1'b0;
            cell_dat_o <= 1'b0;
        end else begin
            win_q      <= win_i;
            pul_q      <= pulse_i;
            cell_stb_o <= win_fall;
            if (win_fall) begin
                cell_clk_o <= seen_clk_q;
                cell_dat_o <= seen_dat_q;
                seen_clk_q <= pul_rise;   // new cell opens in its clock window
                seen_dat_q <= 1'b0;
            end else if (pul_rise) begin
                if (win_i) seen_dat_q <= 1'b1;
                else       seen_clk_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/fmd_frame.sv
// Byte framer: keeps eight cells of data and clock history, spots address
// marks by their missing-clock signature, and once aligned delivers a byte
// every BYTE_W cells. A mark outranks a byte completing on the same cell.
module fmd_frame
    import fmd_pkg::*;
#(
    parameter int BYTE_W = fmd_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cell_stb_i,
    input  logic              cell_clk_i,
    input  logic              cell_dat_i,
    output logic              bit_o,
    output logic              bit_vld_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_vld_o,
    output logic              mark_vld_o,
    output logic [1:0]        mark_type_o
);

    localparam int                CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] dat_sh_q, clk_sh_q, dat_nx, clk_nx;
    logic [CNT_W-1:0]  cnt_q;
    logic              aligned_q;
    mark_hit_t         look;

    // Next history windows and mark classification for the arriving cell
    always_comb begin
        dat_nx = {dat_sh_q[BYTE_W-2:0], cell_dat_i};
        clk_nx = {clk_sh_q[BYTE_W-2:0], cell_clk_i};
        look   = mark_lookup(dat_nx, clk_nx);
    end

    // History, alignment, byte counting and output strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_sh_q    <= '0;
            clk_sh_q    <= '0;
            cnt_q       <= '0;
            aligned_q   <= 1'b0;
            bit_o       <= 1'b0;
            bit_vld_o   <= 1'b0;
            byte_o      <= '0;
            byte_vld_o  <= 1'b0;
            mark_vld_o  <= 1'b0;
            mark_type_o <= 2'd0;
        end else begin
            bit_vld_o  <= 1'b0;
            byte_vld_o <= 1'b0;
            mark_vld_o <= 1'b0;
            if (cell_stb_i) begin
                dat_sh_q  <= dat_nx;
                clk_sh_q  <= clk_nx;
                bit_o     <= cell_dat_i;
                bit_vld_o <= 1'b1;
                if (look.hit) begin
                    aligned_q   <= 1'b1;
                    cnt_q       <= '0;
                    mark_vld_o  <= 1'b1;
                    mark_type_o <= look.kind;
                end else if (aligned_q) begin
                    if (cnt_q == LAST) begin
                        cnt_q      <= '0;
                        byte_vld_o <= 1'b1;
                        byte_o     <= dat_nx;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/fm_sep_decoder.sv
// Top of the FM separated bit decoder. Applies the data polarity, brings
// both separator outputs into the clk domain, frames cells and bytes.
// Assumes clk runs many times faster than the separated clock.
module fm_sep_decoder #(
    parameter int SYNC_STAGES     = 2,
    parameter bit DATA_ACTIVE_LOW = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sep_clk_i,
    input  logic       sep_data_i,
    output logic       bit_o,
    output logic       bit_vld_o,
    output logic [7:0] byte_o,
    output logic       byte_vld_o,
    output logic       mark_vld_o,
    output logic [1:0] mark_type_o
);

    localparam int BYTE_W = fmd_pkg::BYTE_W;

    logic [1:0] raw_pair, sync_pair;
    logic       stb, c_bit, d_bit;

    // Polarity fix ahead of the synchroniser keeps reset idle at zero
    always_comb begin
        raw_pair = {sep_clk_i, sep_data_i ^ DATA_ACTIVE_LOW};
    end

    fmd_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_pair),
        .sync_o  (sync_pair)
    );

    fmd_cell u_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_i      (sync_pair[1]),
        .pulse_i    (sync_pair[0]),
        .cell_stb_o (stb),
        .cell_clk_o (c_bit),
        .cell_dat_o (d_bit)
    );

    fmd_frame #(.BYTE_W(BYTE_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .cell_stb_i  (stb),
        .cell_clk_i  (c_bit),
        .cell_dat_i  (d_bit),
        .bit_o       (bit_o),
        .bit_vld_o   (bit_vld_o),
        .byte_o      (byte_o),
        .byte_vld_o  (byte_vld_o),
        .mark_vld_o  (mark_vld_o),
        .mark_type_o (mark_type_o)
    );

endmodule

// File: rtl/fmd_checker.sv
// Protocol checker for fm_sep_decoder, watching only its ports.
// Keeps its own bit history and cell count to judge byte output.
module fmd_checker #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_o,
    input logic              bit_vld_o,
    input logic [BYTE_W-1:0] byte_o,
    input logic              byte_vld_o,
    input logic              mark_vld_o,
    input logic [1:0]        mark_type_o
);

    logic              seen_mark_q;
    logic [BYTE_W-1:0] hist_q;
    int unsigned       since_q;

    // Independent record of marks, bit history and cells since last frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_mark_q <= 1'b0;
            hist_q      <= '0;
            since_q     <= 0;
        end else begin
            if (bit_vld_o) hist_q <= {hist_q[BYTE_W-2:0], bit_o};
            if (mark_vld_o) begin
                seen_mark_q <= 1'b1;
                since_q     <= 0;
            end else if (byte_vld_o) begin
                since_q <= 0;
            end else if (bit_vld_o && since_q < 255) begin
                since_q <= since_q + 1;
            end
        end
    end

    // R2: a cell strobe lasts one cycle
    p_bit_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld_o |=> !bit_vld_o);

    // R5: marks complete on a cell boundary
    p_mark_on_cell_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mark_vld_o |-> bit_vld_o);

    // R5: the mark code changes only with a mark strobe
    p_mark_code_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mark_type_o) |-> mark_vld_o);

    // R7: a byte is the last eight decoded bits
    p_byte_content_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> byte_o == {hist_q[BYTE_W-2:0], bit_o});

    // R7, R8: a byte completes on the eighth cell after a mark or byte
    p_byte_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> (bit_vld_o && since_q == BYTE_W - 1));

    // R9, R10: no byte without a mark since reset
    p_byte_after_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> seen_mark_q);

    // R11: a mark suppresses the byte on the same cell
    p_mark_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mark_vld_o |-> !byte_vld_o);

endmodule

bind fm_sep_decoder fmd_checker #(.BYTE_W(8)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_o       (bit_o),
    .bit_vld_o   (bit_vld_o),
    .byte_o      (byte_o),
    .byte_vld_o  (byte_vld_o),
    .mark_vld_o  (mark_vld_o),
    .mark_type_o (mark_type_o)
);

// File: tb/tb_fm_sep_decoder.sv
`timescale 1ns/1ps
// Bench: a plain and an active-low instance see the same cell stream;
// their bits, bytes and marks are compared with lists built here.
module tb_fm_sep_decoder;

    localparam int HALF    = 16;     // system cycles per half cell
    localparam int WD_CYC  = 190000;
    localparam int MAXB    = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sep_clk = 1'b1;
    logic sep_data = 1'b0;

    logic [1:0] bit_v, bit_b, byte_v, mark_v;
    logic [7:0] byte_d [2];
    logic [1:0] mark_t [2];

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic       got_bits  [2][64];
    logic [7:0] got_bytes [2][MAXB];
    logic [1:0] got_marks [2][16];
    int nbits [2];
    int nbytes [2];
    int nmarks [2];

    logic       exp_bits  [64];
    logic [7:0] exp_bytes [MAXB];
    logic [1:0] exp_marks [16];
    int n_exp_bits = 0;
    int n_exp_bytes = 0;
    int n_exp_marks = 0;
    bit log_bits = 1'b0;

    always #2 clk = ~clk;

    fm_sep_decoder #(.DATA_ACTIVE_LOW(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .sep_clk_i(sep_clk), .sep_data_i(sep_data),
        .bit_o(bit_b[0]), .bit_vld_o(bit_v[0]), .byte_o(byte_d[0]),
        .byte_vld_o(byte_v[0]), .mark_vld_o(mark_v[0]), .mark_type_o(mark_t[0]));

    fm_sep_decoder #(.DATA_ACTIVE_LOW(1'b1)) dut_n (
        .clk(clk), .rst_n(rst_n), .sep_clk_i(sep_clk), .sep_data_i(~sep_data),
        .bit_o(bit_b[1]), .bit_vld_o(bit_v[1]), .byte_o(byte_d[1]),
        .byte_vld_o(byte_v[1]), .mark_vld_o(mark_v[1]), .mark_type_o(mark_t[1]));

    // Record every output event away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 2; k++) begin
                if (bit_v[k]) begin
                    if (nbits[k] < 64) got_bits[k][nbits[k]] = bit_b[k];
                    nbits[k]++;
                end
                if (byte_v[k]) begin
                    if (nbytes[k] < MAXB) got_bytes[k][nbytes[k]] = byte_d[k];
                    nbytes[k]++;
                end
                if (mark_v[k]) begin
                    if (nmarks[k] < 16) got_marks[k][nmarks[k]] = mark_t[k];
                    nmarks[k]++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One cell: clock window (low) then data window (high), pulses centred
    task automatic send_cell(input logic cb, input logic db);
        for (int i = 0; i < HALF; i++) begin
            @(negedge clk);
            sep_clk  = 1'b0;
            sep_data = cb && (i >= 6) && (i < 9);
        end
        for (int i = 0; i < HALF; i++) begin
            @(negedge clk);
            sep_clk  = 1'b1;
            sep_data = db && (i >= 6) && (i < 9);
        end
        if (log_bits && n_exp_bits < 64) begin
            exp_bits[n_exp_bits] = db;
            n_exp_bits++;
        end
    endtask

    task automatic send_byte(input logic [7:0] d, input logic [7:0] c);
        for (int b = 7; b >= 0; b--) send_cell(c[b], d[b]);
    endtask

    task automatic push_byte(input logic [7:0] v);
        exp_bytes[n_exp_bytes] = v;
        n_exp_bytes++;
    endtask

    task automatic push_mark(input logic [1:0] v);
        exp_marks[n_exp_marks] = v;
        n_exp_marks++;
    endtask

    task automatic check_quiet(input string req);
        for (int k = 0; k < 2; k++) begin
            chk(bit_v[k] == 1'b0, req, "bit_vld at reset", int'(bit_v[k]), 0);
            chk(byte_v[k] == 1'b0, req, "byte_vld at reset", int'(byte_v[k]), 0);
            chk(mark_v[k] == 1'b0, req, "mark_vld at reset", int'(mark_v[k]), 0);
            chk(byte_d[k] == 8'h00, req, "byte at reset", int'(byte_d[k]), 0);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Watchdog: an unfinished run counts as one failed check
    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            nbits[k] = 0; nbytes[k] = 0; nmarks[k] = 0;
        end

        // R1: quiet outputs in and right after reset
        repeat (10) @(negedge clk);
        check_quiet("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1");
        repeat (10) @(negedge clk);

        // R2 R3 R9: ordinary bytes with every clock present, no alignment
        exp_bits[0] = 1'b0;            // the cell closed by the first fall
        n_exp_bits = 1;
        log_bits = 1'b1;
        send_byte(8'hA1, 8'hFF);
        send_byte(8'hFE, 8'hFF);
        send_byte(8'hFC, 8'hFF);
        send_byte(8'h3C, 8'hFF);
        log_bits = 1'b0;
        send_cell(1'b1, 1'b0);         // flush closes the last byte's cell
        settle();
        for (int k = 0; k < 2; k++) begin
            chk(nbits[k] == n_exp_bits, k ? "R4" : "R2", "cell strobe count",
                nbits[k], n_exp_bits);
            for (int i = 0; i < n_exp_bits; i++)
                chk(got_bits[k][i] == exp_bits[i], k ? "R4" : "R3",
                    "decoded bit", int'(got_bits[k][i]), int'(exp_bits[i]));
            chk(nbytes[k] == 0, "R9", "bytes before any mark", nbytes[k], 0);
            chk(nmarks[k] == 0, "R6", "marks with full clock", nmarks[k], 0);
        end

        // R6: ID data value under the index clock signature
        send_byte(8'hFE, 8'hD7);
        send_byte(8'hFB, 8'hD7);
        send_byte(8'hFC, 8'hC7);
        send_cell(1'b1, 1'b0);
        settle();
        for (int k = 0; k < 2; k++) begin
            chk(nmarks[k] == 0, "R6", "marks with wrong clock", nmarks[k], 0);
            chk(nbytes[k] == 0, "R9", "bytes while unaligned", nbytes[k], 0);
        end

        // R5 R7 R11: each mark kind followed by three bytes
        for (int t = 0; t < 4; t++) begin
            case (t)
                0: send_byte(8'hFC, 8'hD7);
                1: send_byte(8'hFE, 8'hC7);
                2: send_byte(8'hFB, 8'hC7);
                default: send_byte(8'hF8, 8'hC7);
            endcase
            push_mark(2'(t));
            for (int j = 0; j < 3; j++) begin
                send_byte(8'(t * 16 + j + 1), 8'hFF);
                push_byte(8'(t * 16 + j + 1));
            end
        end

        // R8: three stray cells, then a data mark; the count completes
        // inside the mark, giving {101, 0xFB>>3} = 0xBF, then realigns
        send_cell(1'b1, 1'b1);
        send_cell(1'b1, 1'b0);
        send_cell(1'b1, 1'b1);
        send_byte(8'hFB, 8'hC7);
        push_byte(8'hBF);
        push_mark(2'd2);

        // R7: every byte value after the realigning mark
        for (int v = 0; v < 256; v++) begin
            send_byte(8'(v), 8'hFF);
            push_byte(8'(v));
        end
        send_cell(1'b1, 1'b0);
        settle();

        for (int k = 0; k < 2; k++) begin
            chk(nmarks[k] == n_exp_marks, "R5", "mark count", nmarks[k], n_exp_marks);
            for (int i = 0; i < n_exp_marks && i < nmarks[k]; i++)
                chk(got_marks[k][i] == exp_marks[i], k ? "R4" : "R5",
                    "mark code", int'(got_marks[k][i]), int'(exp_marks[i]));
            chk(nbytes[k] == n_exp_bytes, "R11", "byte count", nbytes[k], n_exp_bytes);
            for (int i = 0; i < n_exp_bytes && i < nbytes[k]; i++)
                chk(got_bytes[k][i] == exp_bytes[i], (i == 12) ? "R8" : "R7",
                    "byte value", int'(got_bytes[k][i]), int'(exp_bytes[i]));
        end

        // R10: reset mid-stream, then bytes without a mark stay silent
        @(negedge clk);
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check_quiet("R10");
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1");
        repeat (10) @(negedge clk);
        send_byte(8'h55, 8'hFF);
        send_byte(8'hAA, 8'hFF);
        send_cell(1'b1, 1'b0);
        settle();
        for (int k = 0; k < 2; k++) begin
            chk(nbytes[k] == n_exp_bytes, "R10", "bytes after reset",
                nbytes[k], n_exp_bytes);
            chk(nmarks[k] == n_exp_marks, "R10", "marks after reset",
                nmarks[k], n_exp_marks);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule